// File: doc/BRIEF.md
# Windowed GPIO Pin Banks

This block gives a processor word-addressed register access to one or more 32-pin general-purpose I/O banks. Each bank keeps a per-pin direction word and an output latch. Software normally changes the latch through two atomic mask ports. One port raises the masked bits and the other lowers them, so a read-modify-write sequence is not needed. The pad side of each bank is a set of three vectors: the driven value, the output enable and the sampled pin level.

Pin levels pass through a two-stage flip-flop synchronizer before software can read them. A read of the input word therefore shows the pins as they were two clocks earlier. This holds for every pin, including pins that the bank itself is driving. Banks sit one after another in the address window at a fixed pitch of ten words. Addresses that do not name a register read as zero and ignore writes. The bus is single cycle: read data follows the address combinationally, and a write takes effect on the rising clock edge where the write enable is high.

Top module: `gpio_window`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) sets every direction bit to 1 and clears every output-latch bit. After reset all pad_oe bits are 0 and all pad_out bits are 0.
- R2: The direction word is at word offset 0 of a bank (byte 0x00). A direction bit of 1 makes the pin an input and a bit of 0 makes it an output. A write replaces the whole word, and a read returns it.
- R3: A write to word offset 2 (byte 0x08) sets every latch bit whose write-data bit is 1. It leaves the other latch bits unchanged.
- R4: A write to word offset 3 (byte 0x0C) clears every latch bit whose write-data bit is 1. It leaves the other latch bits unchanged.
- R5: A write to word offset 1 (byte 0x04) replaces the whole latch. Reads of word offsets 1, 2 and 3 all return the current latch value.
- R6: A read of word offset 4 (byte 0x10) returns the bank's pad_in level from two rising edges earlier, whatever the pin directions are. Writes to this offset have no effect.
- R7: Bank k occupies word addresses 10k to 10k+9 (a byte pitch of 0x28). Bank k drives pad bits [32k+31:32k]. A write to one bank never changes another bank.
- R8: Word offsets 5 to 9 inside a bank, and every word address from 10*NUM_BANKS upward, read as 0. Writes to them change no register and no pad output.
- R9: pad_out always carries the latch. Each pad_oe bit is the inverse of that pin's direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock; pins are synchronized to it |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address into the bank window |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_out | output | 32*NUM_BANKS | Value driven toward each pad |
| pad_oe | output | 32*NUM_BANKS | Output enable per pad, high means driving |
| pad_in | input | 32*NUM_BANKS | Level observed on each pad |

## Verification
A corrupted direction or latch bit reaches the pads at the next clock edge. It shows up as a wrong pad_oe or pad_out bit, and it also shows on the very next read of offsets 0 to 3. A fault in the mask logic is visible only in bits outside the mask, so the vectors pair set and clear masks that partly overlap bits already set. A synchronizer with the wrong depth shifts the input word by one cycle. To catch that, a pad change is sampled after one edge and again after two. A decode fault appears as data leaking into another bank or into a reserved word, so those words are read back after writes aimed at their neighbours.

// File: rtl/gpio_pkg.sv
// Package: constants and register codes shared by the GPIO bank modules.
// Assumes word addressing; one bank spans STRIDE_WORDS consecutive words.
package gpio_pkg;
    localparam int PINS         = 32;
    localparam int STRIDE_WORDS = 10;
    localparam int OFF_W        = 4;

    typedef enum logic [OFF_W-1:0] {
        REG_DIR = 4'd0,
        REG_OUT = 4'd1,
        REG_SET = 4'd2,
        REG_CLR = 4'd3,
        REG_IN  = 4'd4
    } gpio_reg_e;
endpackage

// File: rtl/gpio_addr_decode.sv
// Module: gpio_addr_decode
// Splits a word address into a one-hot bank select and a word offset inside
// that bank. Uses range compares rather than division.
// Assumes the banks are packed from address 0 at a pitch of STRIDE_WORDS words.
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] bank_sel,
    output logic [OFF_W-1:0]     offset,
    output logic                 in_range
);
    localparam int WIN_WORDS = NUM_BANKS * STRIDE_WORDS;

    // Find the bank whose word range holds the address.
    always_comb begin
        bank_sel = '0;
        offset   = '0;
        in_range = (int'(addr) < WIN_WORDS);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(addr) >= b * STRIDE_WORDS && int'(addr) < (b + 1) * STRIDE_WORDS) begin
                bank_sel[b] = 1'b1;
                offset      = OFF_W'(int'(addr) - b * STRIDE_WORDS);
            end
        end
    end
endmodule

// File: rtl/gpio_pin_sync.sv
// Module: gpio_pin_sync
// Two-flop synchronizer, one chain per pin. Its output lags the pin by two
// rising edges. Assumes pins may change at any time relative to clk.
module gpio_pin_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    // Shift each pin level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= pin;
            q      <= stage1;
        end
    end

    // R6: the synchronized level equals the pin level two edges back.
    a_r6_two_edge_lag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(pin, 2)));
endmodule

// File: rtl/gpio_bank_regs.sv
// Module: gpio_bank_regs
// One bank: a direction word, an output latch with set/clear mask ports, and
// the read mux for the bank's ten words. Writes happen only when bank_sel and
// we are both high. Assumes offset is already relative to this bank.
module gpio_bank_regs
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bank_sel,
    input  logic             we,
    input  logic [OFF_W-1:0] offset,
    input  logic [PINS-1:0]  wdata,
    input  logic [PINS-1:0]  pin_sync,
    output logic [PINS-1:0]  dir,
    output logic [PINS-1:0]  latch,
    output logic [PINS-1:0]  rdata
);
    logic wr;
    assign wr = bank_sel && we;

    // Direction word: reset to all inputs; replaced by a write to REG_DIR.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir <= '1;
        else if (wr && offset == REG_DIR)
            dir <= wdata;
    end

    // Output latch: full replace, or a masked set or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch <= '0;
        else if (wr) begin
            case (offset)
                REG_OUT: latch <= wdata;
                REG_SET: latch <= latch | wdata;
                REG_CLR: latch <= latch & ~wdata;
                default: latch <= latch;
            endcase
        end
    end

    // Read mux; reserved offsets and unselected banks return zero.
    always_comb begin
        rdata = '0;
        if (bank_sel) begin
            case (offset)
                REG_DIR:                  rdata = dir;
                REG_OUT, REG_SET, REG_CLR: rdata = latch;
                REG_IN:                   rdata = pin_sync;
                default:                  rdata = '0;
            endcase
        end
    end

    // R2: a direction write lands whole.
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && offset == REG_DIR) |=> (dir == $past(wdata)));
    // R3: a set write raises masked bits only.
    a_r3_set_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && offset == REG_SET) |=> (latch == ($past(latch) | $past(wdata))));
    // R4: a clear write lowers masked bits only.
    a_r4_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && offset == REG_CLR) |=> (latch == ($past(latch) & ~$past(wdata))));
    // R5: a data write replaces the latch.
    a_r5_out_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && offset == REG_OUT) |=> (latch == $past(wdata)));
    // R7/R8: without a write to this bank its state holds.
    a_r7_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || offset > REG_CLR) |=> ($stable(latch) && $stable(dir)));
endmodule

// File: rtl/gpio_window.sv
// Module: gpio_window
// Top of the GPIO window. It decodes the word address, instantiates
// NUM_BANKS banks with their synchronizers, ORs their read data together and
// drives the pads. Assumes a single-cycle bus whose read data is combinational.
module gpio_window
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [PINS-1:0]           bus_wdata,
    output logic [PINS-1:0]           bus_rdata,
    output logic [NUM_BANKS*PINS-1:0] pad_out,
    output logic [NUM_BANKS*PINS-1:0] pad_oe,
    input  logic [NUM_BANKS*PINS-1:0] pad_in
);
    logic [NUM_BANKS-1:0]           bank_sel;
    logic [OFF_W-1:0]               offset;
    logic                           in_range;
    logic [NUM_BANKS-1:0][PINS-1:0] bank_rdata;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_decode (
        .addr     (bus_addr),
        .bank_sel (bank_sel),
        .offset   (offset),
        .in_range (in_range)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [PINS-1:0] pin_sync;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] latch;

        gpio_pin_sync #(.WIDTH(PINS)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pad_in[b*PINS +: PINS]),
            .q     (pin_sync)
        );

        gpio_bank_regs u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .bank_sel (bank_sel[b]),
            .we       (bus_we),
            .offset   (offset),
            .wdata    (bus_wdata),
            .pin_sync (pin_sync),
            .dir      (dir),
            .latch    (latch),
            .rdata    (bank_rdata[b])
        );

        // Pad drive: the latch value, enabled where direction is 0.
        assign pad_out[b*PINS +: PINS] = latch;
        assign pad_oe[b*PINS +: PINS]  = ~dir;
    end

    // Merge bank read data; at most one bank is selected.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            bus_rdata = bus_rdata | bank_rdata[b];
    end

    // R7: never more than one bank selected.
    a_r7_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));
    // R8: writes outside the window leave the pads untouched.
    a_r8_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !in_range) |=> ($stable(pad_out) && $stable(pad_oe)));
    // R8: reads outside the window return zero.
    a_r8_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_range) |-> (bus_rdata == '0));
    // R1: one clock after reset the pads are released and low.
    a_r1_reset_pads: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_out == '0));
endmodule

// File: tb/gpio_window_tb.sv
// Bench for gpio_window: one loop over a vector table, then directed tests.
module gpio_window_tb;
    localparam int NB = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [7:0]        bus_addr;
    logic              bus_we;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [NB*32-1:0]  pad_out;
    logic [NB*32-1:0]  pad_oe;
    logic [NB*32-1:0]  pad_in;

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    gpio_window #(.ADDR_W(8), .NUM_BANKS(NB)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_in    (pad_in)
    );

    typedef struct packed {
        logic        chk;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    // Each entry is one cycle: a read check before the edge, or a write.
    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'd0,  32'h0,         32'hFFFF_FFFF, 4'd1}, // R1 dir reset
        '{1'b1, 1'b0, 8'd1,  32'h0,         32'h0000_0000, 4'd1}, // R1 latch reset
        '{1'b0, 1'b1, 8'd1,  32'h0000_00F0, 32'h0,         4'd5}, // R5 replace
        '{1'b1, 1'b0, 8'd1,  32'h0,         32'h0000_00F0, 4'd5},
        '{1'b0, 1'b1, 8'd2,  32'h0F00_0001, 32'h0,         4'd3}, // R3 set
        '{1'b1, 1'b0, 8'd1,  32'h0,         32'h0F00_00F1, 4'd3},
        '{1'b0, 1'b1, 8'd3,  32'h0000_0031, 32'h0,         4'd4}, // R4 clear
        '{1'b1, 1'b0, 8'd2,  32'h0,         32'h0F00_00C0, 4'd4},
        '{1'b1, 1'b0, 8'd3,  32'h0,         32'h0F00_00C0, 4'd5}, // R5 alias read
        '{1'b0, 1'b1, 8'd0,  32'hFFFF_0000, 32'h0,         4'd2}, // R2 dir write
        '{1'b1, 1'b0, 8'd0,  32'h0,         32'hFFFF_0000, 4'd2},
        '{1'b1, 1'b0, 8'd4,  32'h0,         32'h1234_5678, 4'd6}, // R6 pins
        '{1'b0, 1'b1, 8'd4,  32'hFFFF_FFFF, 32'h0,         4'd6}, // R6 write ignored
        '{1'b1, 1'b0, 8'd4,  32'h0,         32'h1234_5678, 4'd6},
        '{1'b0, 1'b1, 8'd12, 32'h8000_0000, 32'h0,         4'd7}, // R7 bank1 set
        '{1'b1, 1'b0, 8'd11, 32'h0,         32'h8000_0000, 4'd7},
        '{1'b1, 1'b0, 8'd1,  32'h0,         32'h0F00_00C0, 4'd7}, // R7 bank0 kept
        '{1'b1, 1'b0, 8'd14, 32'h0,         32'hA5A5_0F0F, 4'd7}, // R7 bank1 pins
        '{1'b0, 1'b1, 8'd5,  32'hFFFF_FFFF, 32'h0,         4'd8}, // R8 reserved
        '{1'b1, 1'b0, 8'd5,  32'h0,         32'h0000_0000, 4'd8},
        '{1'b0, 1'b1, 8'd20, 32'hDEAD_BEEF, 32'h0,         4'd8}, // R8 beyond window
        '{1'b1, 1'b0, 8'd20, 32'h0,         32'h0000_0000, 4'd8},
        '{1'b1, 1'b0, 8'd1,  32'h0,         32'h0F00_00C0, 4'd8},
        '{1'b1, 1'b0, 8'd10, 32'h0,         32'hFFFF_FFFF, 4'd8}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        rst_n = 1'b0;
        bus_we = 1'b0;
        bus_addr = '0;
        bus_wdata = '0;
        pad_in = {32'hA5A5_0F0F, 32'h1234_5678};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: pads released and low after reset.
        check("R1 pad_oe", 64'(pad_oe), 64'h0);
        check("R1 pad_out", 64'(pad_out), 64'h0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_addr = VEC[i].addr;
            bus_we = VEC[i].we;
            bus_wdata = VEC[i].wdata;
            #1;
            if (VEC[i].chk) begin
                applied++;
                if (bus_rdata !== VEC[i].exp) begin
                    miscompares++;
                    $display("FAIL vector %0d R%0d: actual %h expected %h",
                             i, VEC[i].req, bus_rdata, VEC[i].exp);
                end
            end
        end
        @(negedge clk);
        bus_we = 1'b0;

        // R9: pads follow latch and inverse direction.
        check("R9 pad_oe", 64'(pad_oe), {32'h0000_0000, 32'h0000_FFFF});
        check("R9 pad_out", 64'(pad_out), {32'h8000_0000, 32'h0F00_00C0});

        // R6: a pin change appears after exactly two edges.
        @(negedge clk);
        pad_in[31:0] = 32'hCAFE_0001;
        read_at(8'd4, rd);
        check("R6 one edge", 64'(rd), 64'h1234_5678);
        read_at(8'd4, rd);
        check("R6 two edges", 64'(rd), 64'hCAFE_0001);

        // R2: output-direction pin 0 enables its pad.
        @(negedge clk);
        bus_addr = 8'd10; bus_we = 1'b1; bus_wdata = 32'hFFFF_FFFE;
        @(negedge clk);
        bus_we = 1'b0;
        check("R2 oe bank1", 64'(pad_oe[63:32]), 64'h1);

        // R1: a reset in mid-run restores the reset state.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset oe", 64'(pad_oe), 64'h0);
        check("R1 re-reset out", 64'(pad_out), 64'h0);
        read_at(8'd0, rd);
        check("R1 re-reset dir", 64'(rd), 64'hFFFF_FFFF);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            applied++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end
endmodule